// File: doc/BRIEF.md
# Peripheral Port Handshake Sequencer

This block runs the control side of a 9-bit side port. The port works in one of two modes. In slave mode, an attached processor owns the bus, and the block keeps its own control pins disabled. In master mode, the block drives the pins itself. It raises a request, waits a programmed number of internal ticks, raises acknowledge, and then pulses a read, write or data strobe. When the strobe ends it gives a one-cycle completion pulse. The data path and the FIFO storage are outside this block. The block only looks at the FIFO's empty and full status and at a transfer-pending input.

An 8-bit configuration word sets all run-time choices: bus style, mode, pin polarities, request-to-acknowledge delay, strobe width and internal tick rate. The block copies this word only while it is idle, so a transfer in flight keeps the settings it started with. A synchronous reset-all input, like the hardware reset, returns the port to slave mode with separate strobes and default polarities.

Top module: `pport_seq`

## Requirements
- R1: During hardware reset, and while `soft_rst_i` is high and one clock afterwards, the held configuration is all zero. In this state `ctl_oe_o`=0, `req_o`=0, `ack_o`=1, `stb_a_o`=1, `stb_b_o`=1 and `done_o`=0.
- R2: Configuration bit 1 selects the mode. When it is 0 (slave mode), `ctl_oe_o` is 0 and no request is ever raised, even if a transfer is pending. When it is 1 (master mode), `ctl_oe_o` is 1.
- R3: A transfer starts only on an internal tick in master mode, and only when `xfer_pend_i` is high and the FIFO can take part. Bit `xfer_dir_i`=0 means a port read, which needs `fifo_empty_i` low. Bit `xfer_dir_i`=1 means a port write, which needs `fifo_full_i` low.
- R4: Configuration bit 2 sets the request polarity. When it is 0, `req_o` is high while active. When it is 1, `req_o` is low while active.
- R5: Configuration bit 3 sets the acknowledge polarity. When it is 0, `ack_o` is low while active. When it is 1, `ack_o` is high while active.
- R6: Configuration bits 5:4 hold a code c. Acknowledge becomes active exactly 2+c internal ticks after request becomes active.
- R7: Configuration bit 6 sets the strobe width. When it is 0, the strobe lasts 1 internal tick. When it is 1, it lasts 2 internal ticks.
- R8: Configuration bit 0 selects the bus style. When it is 0, `stb_a_o` is an active-low read strobe and `stb_b_o` is an active-low write strobe; only the strobe matching the direction ever pulses. When it is 1, `stb_a_o` is an active-low data strobe and `stb_b_o` is a direction line that is 1 for read and 0 for write while a transfer is in progress.
- R9: Configuration bit 7 sets the internal tick rate. When it is 0, one tick is one clock. When it is 1, one tick is two clocks, and the tick enable alternates.
- R10: `done_o` is high for exactly one clock, on the same clock in which the strobe ends. Request and acknowledge become inactive on that same clock.
- R11: Configuration input changes made while a transfer is in progress do not affect that transfer. They take effect once the sequencer is idle again.
- R12: The strobe becomes active exactly one internal tick after acknowledge becomes active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst_i | input | 1 | Synchronous reset-all request |
| cfg_i | input | 8 | Configuration word |
| xfer_pend_i | input | 1 | A transfer is waiting |
| xfer_dir_i | input | 1 | 0 = port read, 1 = port write |
| fifo_empty_i | input | 1 | FIFO empty status |
| fifo_full_i | input | 1 | FIFO full status |
| ctl_oe_o | output | 1 | Port controls are driven (master mode) |
| req_o | output | 1 | Request pin, programmable polarity |
| ack_o | output | 1 | Acknowledge pin, programmable polarity |
| stb_a_o | output | 1 | Read strobe or data strobe, active low |
| stb_b_o | output | 1 | Write strobe or read/write direction line |
| done_o | output | 1 | One-clock transfer completion pulse |

## Verification
Two functions can land in the same cycle: a new configuration word can arrive while a transfer is in flight, and the transfer completes and releases its strobe. The bench starts a transfer with a long delay code. One clock after the request rises, it writes a short delay code. It then expects the gap between request and acknowledge to follow the old code. It expects the very next transfer to follow the new code. A scoreboard measures the timing from the pins. It also checks that `done_o` coincides with the strobe edge and that request and acknowledge release on that same clock.

// File: rtl/pport_pkg.sv
package pport_pkg;
    localparam int CFG_W    = 8;
    localparam int DLY_W    = 2;
    localparam int DLY_BASE = 2;
    localparam int CNT_W    = 3;

    typedef struct packed {
        logic             div;
        logic             wide;
        logic [DLY_W-1:0] dly;
        logic             ack_pol;
        logic             req_pol;
        logic             periph;
        logic             style;
    } cfg_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_REQ  = 2'd1,
        S_ACK  = 2'd2,
        S_STB  = 2'd3
    } seq_st_e;
endpackage

// File: rtl/pport_tick.sv
module pport_tick (
    input  logic clk,
    input  logic rst_n,
    input  logic div_i,
    output logic tick_o
);
    logic phase_d, phase_q;

    always_comb begin
        phase_d = div_i ? ~phase_q : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= phase_d;
    end

    assign tick_o = ~div_i | phase_q;

    // R9
    tick_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_i && $past(div_i)) |-> (tick_o != $past(tick_o)));
endmodule

// File: rtl/pport_fsm.sv
module pport_fsm
    import pport_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst_i,
    input  logic [CFG_W-1:0] cfg_i,
    input  logic             tick_i,
    input  logic             xfer_pend_i,
    input  logic             xfer_dir_i,
    input  logic             fifo_empty_i,
    input  logic             fifo_full_i,
    output seq_st_e          st_o,
    output logic             dir_o,
    output cfg_t             cfg_o,
    output logic             done_o
);
    typedef struct packed {
        seq_st_e          st;
        logic [CNT_W-1:0] cnt;
        logic             dir;
        logic             done;
        cfg_t             cfg;
    } fsm_t;

    fsm_t q, d;
    logic fifo_ok;
    logic [CNT_W-1:0] gap_lim, wid_lim;

    always_comb begin
        fifo_ok = xfer_dir_i ? ~fifo_full_i : ~fifo_empty_i;
        gap_lim = CNT_W'(DLY_BASE) + CNT_W'(q.cfg.dly);
        wid_lim = q.cfg.wide ? CNT_W'(2) : CNT_W'(1);
        d       = q;
        d.done  = 1'b0;
        if (soft_rst_i) begin
            d.st  = S_IDLE;
            d.cnt = '0;
            d.cfg = '0;
        end else begin
            unique case (q.st)
                S_IDLE: begin
                    if (q.cfg.periph && tick_i && xfer_pend_i && fifo_ok) begin
                        d.st  = S_REQ;
                        d.cnt = CNT_W'(1);
                        d.dir = xfer_dir_i;
                    end else begin
                        d.cfg = cfg_t'(cfg_i);
                    end
                end
                S_REQ: begin
                    if (tick_i) begin
                        if (q.cnt == gap_lim) d.st  = S_ACK;
                        else                  d.cnt = q.cnt + CNT_W'(1);
                    end
                end
                S_ACK: begin
                    if (tick_i) begin
                        d.st  = S_STB;
                        d.cnt = CNT_W'(1);
                    end
                end
                S_STB: begin
                    if (tick_i) begin
                        if (q.cnt == wid_lim) begin
                            d.st   = S_IDLE;
                            d.cnt  = '0;
                            d.done = 1'b1;
                        end else begin
                            d.cnt = q.cnt + CNT_W'(1);
                        end
                    end
                end
                default: d.st = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= S_IDLE;
            q.cnt  <= '0;
            q.dir  <= 1'b0;
            q.done <= 1'b0;
            q.cfg  <= '0;
        end else begin
            q <= d;
        end
    end

    assign st_o   = q.st;
    assign dir_o  = q.dir;
    assign cfg_o  = q.cfg;
    assign done_o = q.done;

    // R3
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_REQ && $past(q.st) == S_IDLE) |->
        $past(xfer_pend_i && tick_i && q.cfg.periph &&
              (xfer_dir_i ? !fifo_full_i : !fifo_empty_i)));
    // R11
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != S_IDLE) |-> $stable(q.cfg));
    // R10
    done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);
    // R2
    proc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q.cfg.periph |-> (q.st == S_IDLE));
endmodule

// File: rtl/pport_pins.sv
module pport_pins
    import pport_pkg::*;
(
    input  seq_st_e st_i,
    input  logic    dir_i,
    input  cfg_t    cfg_i,
    output logic    ctl_oe_o,
    output logic    req_o,
    output logic    ack_o,
    output logic    stb_a_o,
    output logic    stb_b_o
);
    logic req_act, ack_act, stb_act;

    always_comb begin
        req_act  = (st_i != S_IDLE);
        ack_act  = (st_i == S_ACK) || (st_i == S_STB);
        stb_act  = (st_i == S_STB);
        ctl_oe_o = cfg_i.periph;
        req_o    = req_act ^ cfg_i.req_pol;
        ack_o    = ~(ack_act ^ cfg_i.ack_pol);
        if (cfg_i.style) begin
            stb_a_o = ~stb_act;
            stb_b_o = req_act ? ~dir_i : 1'b1;
        end else begin
            stb_a_o = ~(stb_act & ~dir_i);
            stb_b_o = ~(stb_act & dir_i);
        end
    end

    // R8
    one_strobe_chk: assert final (cfg_i.style || (stb_a_o | stb_b_o));
endmodule

// File: rtl/pport_seq.sv
module pport_seq
    import pport_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst_i,
    input  logic [CFG_W-1:0] cfg_i,
    input  logic             xfer_pend_i,
    input  logic             xfer_dir_i,
    input  logic             fifo_empty_i,
    input  logic             fifo_full_i,
    output logic             ctl_oe_o,
    output logic             req_o,
    output logic             ack_o,
    output logic             stb_a_o,
    output logic             stb_b_o,
    output logic             done_o
);
    logic    tick;
    seq_st_e st;
    logic    dir;
    cfg_t    cfg_q;

    pport_tick tick_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_i  (cfg_q.div),
        .tick_o (tick)
    );

    pport_fsm fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .soft_rst_i   (soft_rst_i),
        .cfg_i        (cfg_i),
        .tick_i       (tick),
        .xfer_pend_i  (xfer_pend_i),
        .xfer_dir_i   (xfer_dir_i),
        .fifo_empty_i (fifo_empty_i),
        .fifo_full_i  (fifo_full_i),
        .st_o         (st),
        .dir_o        (dir),
        .cfg_o        (cfg_q),
        .done_o       (done_o)
    );

    pport_pins pins_i (
        .st_i     (st),
        .dir_i    (dir),
        .cfg_i    (cfg_q),
        .ctl_oe_o (ctl_oe_o),
        .req_o    (req_o),
        .ack_o    (ack_o),
        .stb_a_o  (stb_a_o),
        .stb_b_o  (stb_b_o)
    );
endmodule

// File: tb/pport_seq_tb_top.sv
`timescale 1ns/1ps
module pport_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 1'b0;
    logic [7:0] cfg = 8'h00;
    logic       pend = 1'b0;
    logic       dir = 1'b0;
    logic       empty = 1'b0;
    logic       full = 1'b0;
    logic       oe, req, ack, sa, sb, done;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    pport_seq dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .soft_rst_i   (soft_rst),
        .cfg_i        (cfg),
        .xfer_pend_i  (pend),
        .xfer_dir_i   (dir),
        .fifo_empty_i (empty),
        .fifo_full_i  (full),
        .ctl_oe_o     (oe),
        .req_o        (req),
        .ack_o        (ack),
        .stb_a_o      (sa),
        .stb_b_o      (sb),
        .done_o       (done)
    );

    typedef struct {
        int   gap;
        int   a2s;
        int   wid;
        logic rpol;
        logic apol;
        logic style;
        logic dir;
    } exp_t;

    exp_t sb_q[$];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic exp_t make_exp(input logic [7:0] c, input logic d);
        exp_t e;
        int   t;
        t       = c[7] ? 2 : 1;
        e.gap   = (2 + int'(c[5:4])) * t;
        e.a2s   = t;
        e.wid   = (c[6] ? 2 : 1) * t;
        e.rpol  = c[2];
        e.apol  = c[3];
        e.style = c[0];
        e.dir   = d;
        return e;
    endfunction

    // Monitor: measures pin timing and compares with the head of the scoreboard
    int   cyc = 0;
    int   t0 = 0, t1 = 0, t2 = 0;
    logic pr = 1'b0, pa = 1'b0, ps = 1'b0;
    logic side_bad = 1'b0;
    always @(negedge clk) begin
        cyc++;
        if (sb_q.size() == 0) begin
            pr = 1'b0; pa = 1'b0; ps = 1'b0; side_bad = 1'b0;
        end else begin
            exp_t e;
            logic r, a, s;
            e = sb_q[0];
            r = (req == ~e.rpol);
            a = (ack == e.apol);
            if (e.style) begin
                s = ~sa;
                if (r && (sb != ~e.dir)) side_bad = 1'b1;
            end else begin
                s = e.dir ? ~sb : ~sa;
                if (e.dir ? ~sa : ~sb) side_bad = 1'b1;
            end
            if (r && !pr) t0 = cyc;
            if (a && !pa) t1 = cyc;
            if (s && !ps) t2 = cyc;
            if (!s && ps) begin
                // R6 R4 R5 R9: request-to-acknowledge gap in clocks
                check((t1 - t0) == e.gap, "R6 req->ack gap", t1 - t0, e.gap);
                // R12: strobe one tick after acknowledge
                check((t2 - t1) == e.a2s, "R12 ack->strobe", t2 - t1, e.a2s);
                // R7: strobe width
                check((cyc - t2) == e.wid, "R7 strobe width", cyc - t2, e.wid);
                // R10: done with strobe release, req/ack released
                check(done == 1'b1, "R10 done at strobe end", int'(done), 1);
                check(!r && !a, "R10 req/ack release", int'({r, a}), 0);
                // R8: bus style encoding of the other line
                check(!side_bad, "R8 style line", int'(side_bad), 0);
                void'(sb_q.pop_front());
                side_bad = 1'b0;
                r = 1'b0; a = 1'b0;
            end
            pr = r; pa = a; ps = s;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: pushes expected timing, then requests a transfer
    task automatic run_xfer(input logic [7:0] c, input logic d,
                            input bit late_cfg, input logic [7:0] c2);
        cfg = c;
        wait_cyc(4);
        sb_q.push_back(make_exp(c, d));
        dir  = d;
        pend = 1'b1;
        while (req != ~c[2]) @(negedge clk);
        pend = 1'b0;
        if (late_cfg) begin
            wait_cyc(1);
            cfg = c2;
        end
        while (!done) @(negedge clk);
        wait_cyc(3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        wait_cyc(3);
        // R1: reset state
        check(oe == 1'b0 && req == 1'b0 && ack == 1'b1 && sa && sb && !done,
              "R1 reset pins", int'({oe, req, ack, sa, sb, done}), 6'b001110);
        rst_n = 1'b1;
        wait_cyc(2);

        // R2: slave mode ignores pending transfer
        cfg = 8'h00; pend = 1'b1; dir = 1'b0;
        wait_cyc(20);
        check(oe == 1'b0, "R2 oe in slave mode", int'(oe), 0);
        check(req == 1'b0, "R2 no request in slave mode", int'(req), 0);
        pend = 1'b0;

        // R3: gating by FIFO status
        cfg = 8'h02; empty = 1'b1; wait_cyc(3);
        check(oe == 1'b1, "R2 oe in master mode", int'(oe), 1);
        pend = 1'b1; dir = 1'b0;
        wait_cyc(20);
        check(req == 1'b0, "R3 read blocked on empty", int'(req), 0);
        dir = 1'b1; full = 1'b1; empty = 1'b0;
        wait_cyc(20);
        check(req == 1'b0, "R3 write blocked on full", int'(req), 0);
        pend = 1'b0; full = 1'b0;
        wait_cyc(2);

        // Transfers across styles, polarities, delays, widths, divide
        run_xfer(8'h02, 1'b0, 1'b0, 8'h00);   // R8 style0 read
        run_xfer(8'h7E, 1'b1, 1'b0, 8'h00);   // R4 R5 R7 write, inverted pins
        run_xfer(8'hA3, 1'b0, 1'b0, 8'h00);   // R9 divide, style1 read
        run_xfer(8'hD7, 1'b1, 1'b0, 8'h00);   // R9 R8 style1 write
        // R11: late configuration change, old timing must apply
        run_xfer(8'h32, 1'b0, 1'b1, 8'h02);
        run_xfer(8'h02, 1'b1, 1'b0, 8'h00);
        check(sb_q.size() == 0, "R11 scoreboard drained", sb_q.size(), 0);

        // R1: soft reset-all
        cfg = 8'h7E; wait_cyc(3);
        check(oe == 1'b1 && req == 1'b1, "R1 pre soft reset", int'({oe, req}), 3);
        soft_rst = 1'b1;
        wait_cyc(2);
        check(oe == 1'b0 && req == 1'b0 && ack == 1'b1,
              "R1 soft reset defaults", int'({oe, req, ack}), 1);
        soft_rst = 1'b0;
        wait_cyc(2);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule